// File: doc/BRIEF.md
# I/O Isolation Policy Guard

This block is a security-state controller that enforces one rule: while the processor runs secure code, an I/O master may not write protected data memory. Wrappers around the system's IP blocks send it event frames. Each frame is tagged with the configuration-register address of the trace-cell trigger that fired. The guard matches each tag against a small table of address/value pairs, follows a security state machine, and raises a DMA-blocking control when the rule is broken.

The table has a second use. After reset the guard replays its entries over the configuration bus, which arms the trace-cell triggers. These include the "program counter in secure range" trigger and the "write to protected memory" trigger. Some entries cannot be armed during boot. For those, the guard asks power management to wake the debug access port, then writes them once the port is awake. Enforcement starts as soon as the boot-time entries are written.

Table entry roles are fixed by index:
- Entry 0 is secure-code entry.
- Entry 1 is secure-code exit.
- Entry 2 is DMA interrupt.
- Entry 3 is protected-memory write.
- Higher entries arm triggers that this rule does not use.

Top module: `io_guard_top`

## Requirements
- R1: After reset, blockDma, secureMode, ioActive, dapPwrReq and errCount are all 0, and the guard is in its boot phase.
- R2: During boot, every entry whose BOOT_MASK bit is 1 is offered on cfgValid/cfgAddr/cfgData in ascending index order, one entry per cycle in which cfgValid and cfgReady are both high. While cfgReady is low, the offered address and data hold steady.
- R3: Event frames that arrive before the last boot-time entry is accepted have no effect: secureMode stays 0 and errCount stays 0.
- R4: After boot, if any BOOT_MASK bit is 0, dapPwrReq rises. The deferred entries are then offered in ascending order, and only while dapPwrAck is high. dapPwrReq falls after the last deferred entry is accepted.
- R5: Outside the violation state, a frame carrying entry 0's address sets secureMode from the next cycle. A frame carrying entry 1's address while secure clears it.
- R6: A frame carrying entry 2's address sets ioActive, and swClear clears it. When both happen in the same cycle, ioActive is set.
- R7: A frame carrying entry 3's address with evFromIo=1 while secure raises blockDma and clears secureMode on the next cycle. The same frame has no effect with evFromIo=0 or outside the secure state.
- R8: blockDma stays high, and every tagged event leaves it and secureMode unchanged, until swClear. The cycle after swClear, both are 0.
- R9: A frame whose tag matches no table address adds one to errCount, saturating at all ones, and has no other effect. Tags of entries 4 and above change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event frame present this cycle |
| evTag | input | ADDR_W | Configuration-register address tag of the event |
| evFromIo | input | 1 | Event was caused by the I/O driver |
| swClear | input | 1 | Software clear of enforcement and I/O activity |
| cfgValid | output | 1 | Configuration write offered |
| cfgReady | input | 1 | Configuration bus accepts the write |
| cfgAddr | output | ADDR_W | Configuration write address |
| cfgData | output | DATA_W | Configuration write value |
| dapPwrReq | output | 1 | Request to power the debug access port |
| dapPwrAck | input | 1 | Debug access port powered |
| blockDma | output | 1 | Enforcement: block DMA writes |
| secureMode | output | 1 | Processor is in the high-security state |
| ioActive | output | 1 | A DMA transaction has been recorded |
| errCount | output | ERR_W | Saturating count of unknown tags |

## Verification
Two functions can land in the same edge: software clear and the recording of a DMA interrupt. Clear and a violating frame can also coincide. The bench provokes both pairs once with directed frames. Random traffic then raises swClear together with tagged frames many more times. A cycle model applies the rules in a fixed order: clear leaves violation, events in violation are dropped, and a DMA interrupt wins over clear. Every output is compared with that model after each edge.

// File: rtl/io_guard_pkg.sv
package io_guard_pkg;

  typedef enum logic [1:0] {
    ST_BOOT   = 2'd0,
    ST_NORMAL = 2'd1,
    ST_SECURE = 2'd2,
    ST_VIOL   = 2'd3
  } guardState_t;

  typedef enum logic [1:0] {
    WALK_BOOT = 2'd0,
    WALK_LATE = 2'd1,
    WALK_IDLE = 2'd2
  } walkState_t;

  // fixed table roles (behaviour depends on these indices)
  localparam int ROLE_ENTRY   = 0;
  localparam int ROLE_EXIT    = 1;
  localparam int ROLE_DMAIRQ  = 2;
  localparam int ROLE_PROTWR  = 3;
  localparam int ROLE_COUNT   = 4;

  typedef struct packed {
    logic unknown;
    logic isEntry;
    logic isExit;
    logic isDmaIrq;
    logic isProtWr;
  } evDecode_t;

  typedef struct packed {
    logic walkStep;
    logic walkRestart;
    logic countUnknown;
    logic setIo;
    logic clrIo;
  } dpStrobe_t;

endpackage

// File: rtl/io_guard_dp.sv
module io_guard_dp
  import io_guard_pkg::*;
#(
  parameter int NUM    = 6,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8,
  parameter logic [NUM*ADDR_W-1:0] TABLE_ADDR = '0,
  parameter logic [NUM*DATA_W-1:0] TABLE_DATA = '0,
  parameter logic [NUM-1:0]        BOOT_MASK  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evTag,
  output evDecode_t         dec,
  output logic              ptrLast,
  output logic              ptrBootFlag,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgData,
  output logic              ioActive,
  output logic [ERR_W-1:0]  errCount
);

  localparam int PTR_W = (NUM > 1) ? $clog2(NUM) : 1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [PTR_W-1:0] ptrQ;
  logic [NUM-1:0]   hitVec;

  // walk pointer over the table
  always_ff @(posedge clk) begin
    if (!rstN)                    ptrQ <= '0;
    else if (strobe.walkRestart)  ptrQ <= '0;
    else if (strobe.walkStep)     ptrQ <= ptrQ + PTR_W'(1);
  end

  assign ptrLast = (ptrQ == PTR_W'(NUM - 1));

  // table read port at the walk pointer
  always_comb begin
    cfgAddr     = '0;
    cfgData     = '0;
    ptrBootFlag = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (ptrQ == PTR_W'(i)) begin
        cfgAddr     = TABLE_ADDR[i*ADDR_W +: ADDR_W];
        cfgData     = TABLE_DATA[i*DATA_W +: DATA_W];
        ptrBootFlag = BOOT_MASK[i];
      end
    end
  end

  // tag comparators, one per table entry
  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign hitVec[g] = evValid && (evTag == TABLE_ADDR[g*ADDR_W +: ADDR_W]);
  end

  assign dec.unknown  = evValid && !(|hitVec);
  assign dec.isEntry  = hitVec[ROLE_ENTRY];
  assign dec.isExit   = hitVec[ROLE_EXIT];
  assign dec.isDmaIrq = hitVec[ROLE_DMAIRQ];
  assign dec.isProtWr = hitVec[ROLE_PROTWR];

  always_ff @(posedge clk) begin
    if (!rstN)                 ioActive <= 1'b0;
    else if (strobe.setIo)     ioActive <= 1'b1;
    else if (strobe.clrIo)     ioActive <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      errCount <= '0;
    else if (strobe.countUnknown && (errCount != ERR_MAX))
      errCount <= errCount + ERR_W'(1);
  end

endmodule

// File: rtl/io_guard_ctrl.sv
module io_guard_ctrl
  import io_guard_pkg::*;
#(
  parameter bit HAS_LATE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  evDecode_t   dec,
  input  logic        evFromIo,
  input  logic        swClear,
  input  logic        cfgReady,
  input  logic        dapPwrAck,
  input  logic        ptrLast,
  input  logic        ptrBootFlag,
  output dpStrobe_t   strobe,
  output guardState_t stateQ,
  output logic        cfgValid,
  output logic        dapPwrReq
);

  walkState_t  walkQ, walkD;
  guardState_t stateD;
  logic        eligible, skip, advance, walkEnd, live;

  assign eligible = ((walkQ == WALK_BOOT) && ptrBootFlag) ||
                    ((walkQ == WALK_LATE) && !ptrBootFlag && dapPwrAck);
  assign skip     = ((walkQ == WALK_BOOT) && !ptrBootFlag) ||
                    ((walkQ == WALK_LATE) && ptrBootFlag);
  assign advance  = skip || (eligible && cfgReady);
  assign walkEnd  = advance && ptrLast;
  assign cfgValid = eligible;
  assign dapPwrReq = (walkQ == WALK_LATE);
  assign live     = (stateQ != ST_BOOT);

  always_comb begin
    walkD = walkQ;
    if (walkEnd) begin
      if (walkQ == WALK_BOOT) walkD = HAS_LATE ? WALK_LATE : WALK_IDLE;
      else                    walkD = WALK_IDLE;
    end
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_BOOT:   if ((walkQ == WALK_BOOT) && walkEnd) stateD = ST_NORMAL;
      ST_NORMAL: if (dec.isEntry) stateD = ST_SECURE;
      ST_SECURE: begin
        if (dec.isProtWr && evFromIo) stateD = ST_VIOL;
        else if (dec.isExit)          stateD = ST_NORMAL;
      end
      ST_VIOL:   if (swClear) stateD = ST_NORMAL;
      default:   stateD = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkQ  <= WALK_BOOT;
      stateQ <= ST_BOOT;
    end else begin
      walkQ  <= walkD;
      stateQ <= stateD;
    end
  end

  always_comb begin
    strobe.walkStep     = advance && !ptrLast;
    strobe.walkRestart  = walkEnd;
    strobe.countUnknown = live && dec.unknown;
    strobe.setIo        = live && dec.isDmaIrq;
    strobe.clrIo        = live && swClear;
  end

endmodule

// File: rtl/io_guard_top.sv
module io_guard_top
  import io_guard_pkg::*;
#(
  parameter int NUM    = 6,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8,
  parameter logic [NUM*ADDR_W-1:0] TABLE_ADDR =
    {10'h054, 10'h050, 10'h04C, 10'h048, 10'h044, 10'h040},
  parameter logic [NUM*DATA_W-1:0] TABLE_DATA =
    {32'h0000_0105, 32'h0000_0104, 32'h1000_0FFF,
     32'h0000_0001, 32'h0000_2000, 32'h0000_1000},
  parameter logic [NUM-1:0] BOOT_MASK = 6'b01_1111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evTag,
  input  logic              evFromIo,
  input  logic              swClear,
  output logic              cfgValid,
  input  logic              cfgReady,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgData,
  output logic              dapPwrReq,
  input  logic              dapPwrAck,
  output logic              blockDma,
  output logic              secureMode,
  output logic              ioActive,
  output logic [ERR_W-1:0]  errCount
);

  localparam bit HAS_LATE = ~&BOOT_MASK;

  if (NUM < ROLE_COUNT) begin : g_bad_num
    initial $error("table needs at least four entries");
  end

  evDecode_t   dec;
  dpStrobe_t   strobe;
  guardState_t stateQ;
  logic        ptrLast, ptrBootFlag;

  io_guard_ctrl #(.HAS_LATE(HAS_LATE)) i_ctrl (
    .clk(clk), .rstN(rstN), .dec(dec), .evFromIo(evFromIo),
    .swClear(swClear), .cfgReady(cfgReady), .dapPwrAck(dapPwrAck),
    .ptrLast(ptrLast), .ptrBootFlag(ptrBootFlag), .strobe(strobe),
    .stateQ(stateQ), .cfgValid(cfgValid), .dapPwrReq(dapPwrReq)
  );

  io_guard_dp #(
    .NUM(NUM), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W),
    .TABLE_ADDR(TABLE_ADDR), .TABLE_DATA(TABLE_DATA), .BOOT_MASK(BOOT_MASK)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evValid(evValid),
    .evTag(evTag), .dec(dec), .ptrLast(ptrLast), .ptrBootFlag(ptrBootFlag),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .ioActive(ioActive),
    .errCount(errCount)
  );

  assign blockDma   = (stateQ == ST_VIOL);
  assign secureMode = (stateQ == ST_SECURE);

endmodule

// File: rtl/io_guard_chk.sv
module io_guard_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              evValid,
  input logic              evFromIo,
  input logic              swClear,
  input logic              cfgValid,
  input logic              cfgReady,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [DATA_W-1:0] cfgData,
  input logic              dapPwrReq,
  input logic              dapPwrAck,
  input logic              blockDma,
  input logic              secureMode,
  input logic [ERR_W-1:0]  errCount
);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && !cfgReady |=> (cfgValid || (dapPwrReq && !dapPwrAck))
                              && $stable(cfgAddr) && $stable(cfgData));

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dapPwrReq) |-> $past(cfgValid && cfgReady));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(secureMode && blockDma));

  assert_block_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockDma) |-> $past(evValid && evFromIo && secureMode));

  assert_block_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    blockDma && !swClear |=> blockDma);

  assert_err_monotone_R9: assert property (@(posedge clk) disable iff (!rstN)
    errCount != '0 |=> errCount >= $past(errCount));

endmodule

bind io_guard_top io_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
) i_chk (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evFromIo(evFromIo),
  .swClear(swClear), .cfgValid(cfgValid), .cfgReady(cfgReady),
  .cfgAddr(cfgAddr), .cfgData(cfgData), .dapPwrReq(dapPwrReq),
  .dapPwrAck(dapPwrAck), .blockDma(blockDma), .secureMode(secureMode),
  .errCount(errCount)
);

// File: tb/test_io_guard_top.sv
`timescale 1ns/1ps
module test_io_guard_top;

  localparam int NUM = 6;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0;
  logic [ADDR_W-1:0] evTag = '0;
  logic evFromIo = 1'b0;
  logic swClear = 1'b0;
  logic cfgReady = 1'b0;
  logic dapPwrAck = 1'b0;
  logic cfgValid, dapPwrReq, blockDma, secureMode, ioActive;
  logic [ADDR_W-1:0] cfgAddr;
  logic [DATA_W-1:0] cfgData;
  logic [ERR_W-1:0] errCount;

  int checks = 0;
  int errors = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  // model state
  bit mSec, mViol, mIo;
  int mErr;

  always #2 clk = ~clk;

  io_guard_top i_io_guard_top (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evTag(evTag),
    .evFromIo(evFromIo), .swClear(swClear), .cfgValid(cfgValid),
    .cfgReady(cfgReady), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .dapPwrReq(dapPwrReq), .dapPwrAck(dapPwrAck), .blockDma(blockDma),
    .secureMode(secureMode), .ioActive(ioActive), .errCount(errCount)
  );

  function automatic logic [ADDR_W-1:0] tagOf(int i);
    return ADDR_W'(10'h040 + 4 * i);
  endfunction

  function automatic logic [DATA_W-1:0] dataOf(int i);
    case (i)
      0: return 32'h0000_1000;
      1: return 32'h0000_2000;
      2: return 32'h0000_0001;
      3: return 32'h1000_0FFF;
      4: return 32'h0000_0104;
      default: return 32'h0000_0105;
    endcase
  endfunction

  function automatic bit bootFlag(int i);
    return i != 5;
  endfunction

  function automatic int roleOf(logic [ADDR_W-1:0] t);
    for (int i = 0; i < NUM; i++) if (t == tagOf(i)) return i;
    return -1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one enforcing cycle: model update, edge, compare
  task automatic cyc(bit v, logic [ADDR_W-1:0] t, bit io, bit clr);
    int r;
    evValid = v; evTag = t; evFromIo = io; swClear = clr;
    r = v ? roleOf(t) : -2;
    if (mViol) begin
      if (clr) mViol = 0;
    end else if (mSec) begin
      if (r == 3 && io) begin mViol = 1; mSec = 0; end
      else if (r == 1) mSec = 0;
    end else if (r == 0) mSec = 1;
    if (r == 2) mIo = 1; else if (clr) mIo = 0;
    if (r == -1 && mErr < 255) mErr++;
    @(posedge clk); #1;
    check("R5", "secureMode", secureMode, mSec);
    check(mViol ? "R8" : "R7", "blockDma", blockDma, mViol);
    check("R6", "ioActive", ioActive, mIo);
    check("R9", "errCount", errCount, mErr);
  endtask

  function automatic logic [ADDR_W-1:0] unknownTag();
    logic [ADDR_W-1:0] t = ADDR_W'($urandom);
    if (roleOf(t) >= 0) t = t ^ 10'h200;
    return t;
  endfunction

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int wrIdx;
    int expIdx [$];
    int guard;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM; i++) if (bootFlag(i)) expIdx.push_back(i);
    for (int i = 0; i < NUM; i++) if (!bootFlag(i)) expIdx.push_back(i);

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "blockDma", blockDma, 0);
    check("R1", "secureMode", secureMode, 0);
    check("R1", "ioActive", ioActive, 0);
    check("R1", "dapPwrReq", dapPwrReq, 0);
    check("R1", "errCount", errCount, 0);
    rstN = 1'b1;

    // boot walk with random stalls and stray events (R2, R3)
    wrIdx = 0;
    guard = 0;
    while (wrIdx < 5 && guard < 2000) begin
      guard++;
      cfgReady = ($urandom % 2) == 0;
      evValid  = (wrIdx < 4) && (($urandom % 2) == 0);
      evTag    = (($urandom % 2) == 0) ? tagOf(0) : unknownTag();
      evFromIo = 1'b1;
      #1;
      if (cfgValid && cfgReady) begin
        check("R2", "cfgAddr", cfgAddr, tagOf(expIdx[wrIdx]));
        check("R2", "cfgData", cfgData, dataOf(expIdx[wrIdx]));
        wrIdx++;
      end
      @(posedge clk); #1;
      check("R3", "secureMode during boot", secureMode, 0);
      check("R3", "errCount during boot", errCount, 0);
    end
    check("R2", "boot writes", wrIdx, 5);
    evValid = 1'b0;
    cfgReady = 1'b1;

    // deferred entry waits for power acknowledge (R4)
    for (int k = 0; k < 8; k++) begin
      #1;
      if (cfgValid) check("R4", "cfgValid without ack", 1, 0);
      @(posedge clk); #1;
    end
    check("R4", "dapPwrReq raised", dapPwrReq, 1);
    dapPwrAck = 1'b1;
    #1;
    check("R4", "cfgValid with ack", cfgValid, 1);
    check("R4", "late cfgAddr", cfgAddr, tagOf(expIdx[5]));
    check("R4", "late cfgData", cfgData, dataOf(expIdx[5]));
    @(posedge clk); #1;
    check("R4", "dapPwrReq dropped", dapPwrReq, 0);
    dapPwrAck = 1'b0;
    cfgReady = 1'b0;

    mSec = 0; mViol = 0; mIo = 0; mErr = 0;
    // directed corners
    cyc(1, tagOf(3), 1, 0);   // R7 write outside secure: no effect
    cyc(1, tagOf(0), 0, 0);   // R5 enter
    cyc(1, tagOf(0), 0, 0);   // R5 re-enter
    cyc(1, tagOf(3), 0, 0);   // R7 not from I/O
    cyc(1, tagOf(3), 1, 0);   // R7 violation
    cyc(1, tagOf(0), 0, 0);   // R8 ignored
    cyc(1, tagOf(1), 0, 0);   // R8 ignored
    cyc(1, tagOf(2), 0, 1);   // R8 clear + R6 set wins
    cyc(0, '0, 0, 1);         // R6 clear
    cyc(1, tagOf(4), 0, 0);   // R9 extra entry
    cyc(1, tagOf(5), 1, 0);   // R9 extra entry
    cyc(1, unknownTag(), 0, 0); // R9 unknown
    cyc(1, tagOf(0), 0, 0);
    cyc(1, tagOf(3), 1, 1);   // R7 violation with coincident clear
    cyc(1, tagOf(3), 1, 1);   // R8 clear leaves violation

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int pick = $urandom % 8;
      cyc(($urandom % 10) < 7, (pick < 6) ? tagOf(pick) : unknownTag(),
          ($urandom % 2) == 0, ($urandom % 10) == 0);
    end

    // R9 saturation
    for (int n = 0; n < 280; n++) cyc(1, unknownTag(), 0, 0);
    check("R9", "saturated errCount", errCount, 255);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule